// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is a full-duplex SPI port that can run as the bus master or as a selected slave. Every SCK cycle moves one bit out and takes one bit in, most significant bit first. Words are 8 or 16 bits long. Clock polarity and clock phase are set by configuration inputs. As master, the port makes SCK from the system clock through a 16-bit divider and pulls low one of seven active-low select outputs. As slave, the port follows an external SCK while its single select input is low.

Software or a DMA engine loads a one-word transmit buffer and takes words from a receive register. When a word is complete, the port pulses an interrupt and sets a receive-full flag. A receive-overflow flag marks a word that was lost because the previous one was never read. In the request/acknowledge mode, a loaded word counter controls how many words are fetched and counted. The run ends with a done pulse when that count goes from one to zero.

Top module: `spi_port`

## Requirements
- R1: As master, a 16-bit word in the transmit buffer is shifted out on `mosi_o` MSB first while `miso_i` is sampled in parallel. With `mosi_o` looped to `miso_i`, `rx_data` equals the sent word. One word takes 16 SCK periods.
- R2: With `cfg_wide`=0, only bits 7:0 of the transmit word are sent (8 SCK periods), and `rx_data[15:8]` reads zero.
- R3: SCK idles at `cfg_cpol`. With `cfg_cpha`=0, data is sampled on the leading SCK edge (the edge leaving the idle level) and changed on the trailing edge. With `cfg_cpha`=1, data is changed on the leading edge and sampled on the trailing edge.
- R4: As master, each SCK half period lasts `cfg_baud` system clocks. Values 0 and 1 act as 2.
- R5: As master with `cfg_sel`=k (1..7), `ss_n_o[k-1]` is low for the whole word and every other select stays high. With `cfg_sel`=0, no select goes low. At most one select is ever low.
- R6: As slave, with `ss_n_i` low, the port samples `mosi_i` and drives the buffered transmit word MSB first on `miso_o`, at the edges given by R3.
- R7: As slave, a word that begins while the transmit buffer is empty is sent as all zeros.
- R8: As slave, a rise of `ss_n_i` clears the bit count. A partly received word is dropped, sets no flag and raises no interrupt.
- R9: After the last bit of each word, `irq` pulses for one cycle, `rx_data` takes the word, and `rx_full` is set. A one-cycle `rx_rd` clears `rx_full`.
- R10: When a word completes while `rx_full` is still set and not being read, `rx_ovf` is set and the new word replaces the old one. `rx_rd` clears `rx_ovf`.
- R11: With `cfg_dma`=1 and a count N loaded by `dma_load`, `dma_req` is high while the transmit buffer is empty and fewer than N words have been acknowledged. Each `dma_ack` writes `tx_data` into the buffer. `dma_done` pulses once when the completed-word count steps from 1 to 0, and no request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfg_baud | input | 16 | SCK half period in system clocks (min 2) |
| cfg_sel | input | 3 | Master select output index, 0 = none |
| cfg_dma | input | 1 | Enable request/acknowledge word transfer |
| tx_wr | input | 1 | Write `tx_data` into the transmit buffer |
| tx_data | input | 16 | Transmit word (also used on `dma_ack`) |
| rx_rd | input | 1 | Acknowledge read of `rx_data` |
| rx_data | output | 16 | Last received word |
| rx_full | output | 1 | Unread received word present |
| rx_ovf | output | 1 | A received word was overwritten unread |
| irq | output | 1 | One-cycle pulse per completed word |
| dma_load | input | 1 | Load the word counter |
| dma_count | input | 16 | Word count to load |
| dma_req | output | 1 | Request for the next transmit word |
| dma_ack | input | 1 | Request served, word on `tx_data` |
| dma_done | output | 1 | Pulse when the count reaches zero |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| ss_n_o | output | 7 | Active-low slave selects (master role) |
| sck_i | input | 1 | Slave serial clock |
| mosi_i | input | 1 | Slave data in |
| ss_n_i | input | 1 | Active-low select of this port (slave role) |
| miso_o | output | 1 | Slave data out |

## Verification
The slave corner cases are the hardest to reach from the ports. These are a select dropped partway through a word, a word that starts with an empty transmit buffer, and two words in a row with no read between them. They need a modelled external master whose SCK, select and data timing the bench fully controls. The bench drives `sck_i`, `mosi_i` and `ss_n_i` with half periods well above the input synchronizer delay. It aborts a frame after five bits, runs frames without loading the buffer, and withholds `rx_rd` across two frames. It then reads the flags and `miso_o` at the ports. The counter-driven master run is reached by a responder that answers each `dma_req` with an acknowledge and a fresh word, so that requests, completions and the done pulse interleave as the block sees fit.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned DIV_W   = 16;
  localparam int unsigned SEL_N   = 7;
  localparam int unsigned MIN_DIV = 2;

  // Edge events seen by the shift engine.
  typedef struct packed {
    logic lead;
    logic trail;
  } spi_ev_t;
endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int unsigned DIV_W = spi_port_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] baud,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(spi_port_pkg::MIN_DIV);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = (baud < FLOOR) ? FLOOR : baud;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == half - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  active,
  input  logic                  cpol,
  input  logic                  sck_i,
  input  logic                  mosi_i,
  input  logic                  ss_n_i,
  output spi_port_pkg::spi_ev_t ev,
  output logic                  din,
  output logic                  sel,
  output logic                  start
);
  logic [2:0] sck_q;
  logic [1:0] dat_q;
  logic [2:0] ss_q;
  logic       edge_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      dat_q <= '0;
      ss_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      dat_q <= {dat_q[0], mosi_i};
      ss_q  <= {ss_q[1:0], ss_n_i};
    end
  end

  assign edge_seen = sck_q[1] != sck_q[2];
  assign sel       = active && !ss_q[1];
  assign start     = sel && ss_q[2];
  assign din       = dat_q[1];
  assign ev.lead   = sel && edge_seen && (sck_q[1] != cpol);
  assign ev.trail  = sel && edge_seen && (sck_q[1] == cpol);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = spi_port_pkg::WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wide,
  input  logic                  cpha,
  input  spi_port_pkg::spi_ev_t ev,
  input  logic                  load,
  input  logic                  clr,
  input  logic [W-1:0]          next_word,
  input  logic                  din,
  output logic                  dout,
  output logic                  wrap,
  output logic                  end_edge,
  output logic                  done,
  output logic [W-1:0]          rx_word
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [W-1:0] LOW_MASK = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};

  logic [CW-1:0] cnt;
  logic [CW-1:0] bits;
  logic [CW-1:0] oidx;
  logic [W-1:0]  tw;
  logic [W-1:0]  rw;
  logic [W-1:0]  rw_next;
  logic [W-1:0]  out_sh;
  logic [W-1:0]  ld_sh;
  logic          samp;
  logic          shf;

  assign bits    = wide ? CW'(W) : CW'(W/2);
  assign oidx    = bits - 1'b1 - cnt;
  assign samp    = cpha ? ev.trail : ev.lead;
  assign shf     = cpha ? ev.lead : ev.trail;
  assign wrap    = samp && (cnt == bits - 1'b1);
  assign rw_next = {rw[W-2:0], din};
  assign out_sh  = tw >> oidx;
  assign ld_sh   = next_word >> (bits - 1'b1);
  // Last edge of a word: the trailing edge that leaves the count at zero.
  assign end_edge = ev.trail && (cpha ? wrap : (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tw      <= '0;
      rw      <= '0;
      dout    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        tw   <= next_word;
        cnt  <= '0;
        dout <= ld_sh[0];
      end else if (clr) begin
        cnt <= '0;
      end else begin
        if (samp) begin
          rw <= rw_next;
          if (wrap) begin
            cnt     <= '0;
            tw      <= next_word;
            done    <= 1'b1;
            rx_word <= wide ? rw_next : (rw_next & LOW_MASK);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (shf) begin
          dout <= out_sh[0];
        end
      end
    end
  end
endmodule

// File: rtl/spi_dma_track.sv
module spi_dma_track #(
  parameter int unsigned CNT_W = spi_port_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ack,
  input  logic             word_done,
  input  logic             buf_full,
  output logic             req,
  output logic             done
);
  logic [CNT_W-1:0] req_left;
  logic [CNT_W-1:0] done_left;

  assign req = en && (req_left != '0) && !buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_left  <= '0;
      done_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        req_left  <= load_val;
        done_left <= load_val;
      end else begin
        if (ack && req_left != '0) begin
          req_left <= req_left - 1'b1;
        end
        if (en && word_done && done_left != '0) begin
          done_left <= done_left - 1'b1;
          done      <= (done_left == CNT_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned W     = spi_port_pkg::WORD_W,
  parameter int unsigned DIV_W = spi_port_pkg::DIV_W,
  parameter int unsigned SEL_N = spi_port_pkg::SEL_N,
  parameter int unsigned SEL_W = $clog2(SEL_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_master,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_wide,
  input  logic [DIV_W-1:0] cfg_baud,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_dma,
  input  logic             tx_wr,
  input  logic [W-1:0]     tx_data,
  input  logic             rx_rd,
  output logic [W-1:0]     rx_data,
  output logic             rx_full,
  output logic             rx_ovf,
  output logic             irq,
  input  logic             dma_load,
  input  logic [DIV_W-1:0] dma_count,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic             dma_done,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [SEL_N-1:0] ss_n_o,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             ss_n_i,
  output logic             miso_o
);
  import spi_port_pkg::*;

  logic          m_mode, s_mode;
  logic          busy, busy_next, sck_r, tick;
  logic          m_start, m_end;
  logic [W-1:0]  txbuf;
  logic          txfull, wr_any, consume;
  logic [W-1:0]  next_word;
  spi_ev_t       m_ev, s_ev, ev;
  logic          s_din, s_sel, s_start;
  logic          core_din, core_dout, wrap, end_edge, word_done;
  logic [W-1:0]  rx_word;

  assign m_mode = cfg_en && cfg_master;
  assign s_mode = cfg_en && !cfg_master;

  // Transmit buffer: one word, written by software or by an acknowledge.
  assign wr_any    = tx_wr || dma_ack;
  assign m_start   = m_mode && !busy && txfull;
  assign consume   = m_start || (s_mode && (s_start || wrap));
  assign next_word = txfull ? txbuf : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      txbuf  <= '0;
      txfull <= 1'b0;
    end else begin
      if (wr_any) begin
        txbuf  <= tx_data;
        txfull <= 1'b1;
      end else if (consume) begin
        txfull <= 1'b0;
      end
    end
  end

  // Master clock generation.
  spi_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .baud (cfg_baud),
    .tick (tick)
  );

  assign m_ev.lead  = busy && tick && (sck_r == cfg_cpol);
  assign m_ev.trail = busy && tick && (sck_r != cfg_cpol);
  assign m_end      = m_mode && end_edge;
  assign busy_next  = m_mode && (m_start || (busy && !m_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sck_r <= 1'b0;
    end else begin
      busy <= busy_next;
      if (!busy) begin
        sck_r <= cfg_cpol;
      end else if (tick) begin
        sck_r <= ~sck_r;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < SEL_N; gi++) begin : g_sel
      always_ff @(posedge clk) begin
        if (rst) begin
          ss_n_o[gi] <= 1'b1;
        end else begin
          ss_n_o[gi] <= !(busy_next && (cfg_sel == SEL_W'(gi + 1)));
        end
      end
    end
  endgenerate

  // Slave front end.
  spi_slave_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .active (s_mode),
    .cpol   (cfg_cpol),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .ss_n_i (ss_n_i),
    .ev     (s_ev),
    .din    (s_din),
    .sel    (s_sel),
    .start  (s_start)
  );

  assign ev       = m_mode ? m_ev : (s_mode ? s_ev : '0);
  assign core_din = m_mode ? miso_i : s_din;

  spi_shift_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .wide      (cfg_wide),
    .cpha      (cfg_cpha),
    .ev        (ev),
    .load      (m_start || s_start),
    .clr       (s_mode && !s_sel),
    .next_word (next_word),
    .din       (core_din),
    .dout      (core_dout),
    .wrap      (wrap),
    .end_edge  (end_edge),
    .done      (word_done),
    .rx_word   (rx_word)
  );

  assign sck_o  = sck_r;
  assign mosi_o = core_dout;
  assign miso_o = s_mode ? core_dout : 1'b0;

  // Receive side.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovf  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= word_done;
      if (word_done) begin
        rx_data <= rx_word;
        rx_full <= 1'b1;
        if (rx_full && !rx_rd) begin
          rx_ovf <= 1'b1;
        end
      end else if (rx_rd) begin
        rx_full <= 1'b0;
        rx_ovf  <= 1'b0;
      end
    end
  end

  spi_dma_track #(.CNT_W(DIV_W)) u_dma (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_dma),
    .load      (dma_load),
    .load_val  (dma_count),
    .ack       (dma_ack),
    .word_done (word_done),
    .buf_full  (txfull),
    .req       (dma_req),
    .done      (dma_done)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int unsigned SEL_N = 7,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_master,
  input logic             cfg_cpol,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             rx_full,
  input logic             rx_ovf,
  input logic             irq,
  input logic             dma_req,
  input logic             dma_ack,
  input logic             dma_done,
  input logic             sck_o,
  input logic [SEL_N-1:0] ss_n_o
);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ss_n_o));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_master && cfg_sel != '0 && (&ss_n_o) &&
     $stable(cfg_cpol) && $stable(cfg_master) && $stable(cfg_en) && $stable(cfg_sel))
    |-> (sck_o == cfg_cpol));

  // R9
  irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_full);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> irq);

  // R11
  req_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dma_ack) |=> !dma_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dma_done |=> !dma_done);
endmodule

bind spi_port spi_port_chk #(.SEL_N(SEL_N), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .cfg_master (cfg_master),
  .cfg_cpol   (cfg_cpol),
  .cfg_sel    (cfg_sel),
  .rx_full    (rx_full),
  .rx_ovf     (rx_ovf),
  .irq        (irq),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .dma_done   (dma_done),
  .sck_o      (sck_o),
  .ss_n_o     (ss_n_o)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int CLK_P = 10;
  localparam int H     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0, cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic        cfg_wide = 1'b1, cfg_dma = 1'b0;
  logic [15:0] cfg_baud = 16'd2;
  logic [2:0]  cfg_sel = 3'd0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, dma_load = 1'b0, dma_ack = 1'b0;
  logic [15:0] tx_data = '0, dma_count = '0;
  logic [15:0] rx_data;
  logic        rx_full, rx_ovf, irq, dma_req, dma_done;
  logic        sck_o, mosi_o, miso_i, miso_o;
  logic [6:0]  ss_n_o;
  logic        sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit resp_on = 0;
  int acks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  assign miso_i = mosi_o;

  spi_port dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
    .cfg_baud(cfg_baud), .cfg_sel(cfg_sel), .cfg_dma(cfg_dma),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_full(rx_full), .rx_ovf(rx_ovf), .irq(irq),
    .dma_load(dma_load), .dma_count(dma_count), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_done(dma_done),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o),
    .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // Monitor: every completed word is compared against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && irq) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected word", rx_data, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rx_data == e, t, rx_data, e);
        end
      end
    end
  end

  // Request responder for the counted run.
  initial begin
    forever begin
      @(negedge clk);
      if (resp_on && dma_req && !dma_ack) begin
        tx_data = 16'h4D00 + 16'(acks * 16'h0111);
        push(tx_data, "R11 word");
        dma_ack = 1'b1;
        acks++;
      end else begin
        dma_ack = 1'b0;
      end
    end
  end

  task automatic write_tx(input logic [15:0] w);
    @(negedge clk);
    tx_data = w;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_run(input logic [15:0] w, input logic [15:0] exp_rx, input int bits,
                            input int half, input logic [6:0] ss_exp, input string tag);
    int  tog = 0, first = -1, second = -1, cyc = 0;
    bit  ss_ok = 1, irq_seen = 0;
    logic prev;
    push(exp_rx, tag);
    write_tx(w);
    prev = sck_o;
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (sck_o != prev) begin
        tog++;
        if (first < 0) first = cyc;
        else if (second < 0) second = cyc;
      end
      prev = sck_o;
      if (sck_o != cfg_cpol && ss_n_o != ss_exp) ss_ok = 0;
      if (irq) irq_seen = 1;
      if (irq_seen && (&ss_n_o) && sck_o == cfg_cpol) break;
    end
    check(tog == 2 * bits, {tag, " sck edge count"}, tog, 2 * bits);
    check(second - first == half, "R4 half period", second - first, half);
    check(ss_ok, "R5 select during word", ss_n_o, ss_exp);
    read_rx();
  endtask

  // External master model driving the slave port, cpol = 0.
  task automatic slave_word(input logic [15:0] mw, input int bits, input bit cpha,
                            output logic [15:0] sw);
    sw = '0;
    for (int i = bits - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = mw[i];
        wait_n(H);
        sw = {sw[14:0], miso_o};
        sck_i = 1'b1;
        wait_n(H);
        sck_i = 1'b0;
      end else begin
        sck_i = 1'b1;
        mosi_i = mw[i];
        wait_n(H);
        sw = {sw[14:0], miso_o};
        sck_i = 1'b0;
        wait_n(H);
      end
    end
    wait_n(H);
  endtask

  task automatic frame_on();
    @(negedge clk);
    ss_n_i = 1'b0;
    wait_n(H);
  endtask

  task automatic frame_off();
    @(negedge clk);
    ss_n_i = 1'b1;
    wait_n(H);
  endtask

  initial begin
    logic [15:0] sw;
    int dones;
    int cyc;
    bit late_req;

    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // Reset state
    check(sck_o == 1'b0 && ss_n_o == 7'h7F, "R5 reset outputs", {sck_o, ss_n_o}, 8'h7F);
    check(!rx_full && !rx_ovf && !irq && !dma_req, "R9 reset flags",
          {rx_full, rx_ovf, irq, dma_req}, 0);

    // Master, 16-bit, mode 0, divider 3, select 2
    cfg_en = 1; cfg_master = 1; cfg_baud = 16'd3; cfg_sel = 3'd2;
    master_run(16'hA5C3, 16'hA5C3, 16, 3, 7'b1111101, "R1");
    check(!rx_full, "R9 read clears full", rx_full, 0);

    // Master, 16-bit, divider 1 acts as 2, select 7
    cfg_baud = 16'd1; cfg_sel = 3'd7;
    master_run(16'h0F81, 16'h0F81, 16, 2, 7'b0111111, "R1");

    // Master, 8-bit, mode 3, divider 0 acts as 2, select 1
    cfg_wide = 0; cfg_cpol = 1; cfg_cpha = 1; cfg_baud = 16'd0; cfg_sel = 3'd1;
    wait_n(4);
    check(sck_o == 1'b1, "R3 idle level high", sck_o, 1);
    master_run(16'h12F0, 16'h00F0, 8, 2, 7'b1111110, "R2");

    // Master with no select
    cfg_cpol = 0; cfg_cpha = 0; cfg_sel = 3'd0; cfg_baud = 16'd2;
    wait_n(4);
    master_run(16'h003C, 16'h003C, 8, 2, 7'h7F, "R5 no select");

    // Slave, 16-bit, mode 0
    cfg_master = 0; cfg_wide = 1; cfg_cpha = 0;
    wait_n(4);
    write_tx(16'h3C96);
    push(16'h5AA5, "R6 slave rx");
    frame_on();
    slave_word(16'h5AA5, 16, 0, sw);
    frame_off();
    check(sw == 16'h3C96, "R6 slave tx", sw, 16'h3C96);
    read_rx();

    // Slave with an empty buffer sends zeros
    push(16'hF0F0, "R7 slave rx");
    frame_on();
    slave_word(16'hF0F0, 16, 0, sw);
    frame_off();
    check(sw == 16'h0000, "R7 zero word", sw, 0);
    read_rx();

    // Slave, 8-bit, mode 1
    cfg_wide = 0; cfg_cpha = 1;
    write_tx(16'hABC5);
    push(16'h003E, "R3 phase one rx");
    frame_on();
    slave_word(16'h003E, 8, 1, sw);
    frame_off();
    check(sw == 16'h00C5, "R3 phase one tx", sw, 16'h00C5);
    read_rx();

    // Partial frame is dropped
    cfg_wide = 1; cfg_cpha = 0;
    frame_on();
    slave_word(16'hFFFF, 5, 0, sw);
    frame_off();
    check(!rx_full, "R8 partial word no flag", rx_full, 0);
    push(16'h1234, "R8 full word after abort");
    frame_on();
    slave_word(16'h1234, 16, 0, sw);
    frame_off();
    read_rx();

    // Overflow: two frames without a read
    push(16'h0A0A, "R10 first");
    push(16'hC3C3, "R10 second");
    frame_on();
    slave_word(16'h0A0A, 16, 0, sw);
    frame_off();
    check(!rx_ovf && rx_full, "R10 no overflow yet", rx_ovf, 0);
    frame_on();
    slave_word(16'hC3C3, 16, 0, sw);
    frame_off();
    check(rx_ovf == 1'b1, "R10 overflow set", rx_ovf, 1);
    check(rx_data == 16'hC3C3, "R10 newest kept", rx_data, 16'hC3C3);
    read_rx();
    check(!rx_ovf && !rx_full, "R10 read clears", {rx_ovf, rx_full}, 0);

    // Counted request run, master, 16-bit
    cfg_master = 1; cfg_sel = 3'd3; cfg_baud = 16'd2; cfg_dma = 1;
    wait_n(4);
    @(negedge clk);
    dma_count = 16'd3;
    dma_load = 1'b1;
    @(negedge clk);
    dma_load = 1'b0;
    resp_on = 1;
    dones = 0;
    late_req = 0;
    cyc = 0;
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      rx_rd = irq;
      if (dma_done) dones++;
      if (dones > 0 && dma_req) late_req = 1;
    end
    rx_rd = 1'b0;
    resp_on = 0;
    check(acks == 3, "R11 acknowledge count", acks, 3);
    check(dones == 1, "R11 single done pulse", dones, 1);
    check(!late_req, "R11 no request after done", late_req, 0);
    check(exp_q.size() == 0, "R11 all words received", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule